// File: doc/BRIEF.md
# Slot-Matched Gateway Transmit Scheduler

The block schedules outbound traffic for one network gateway that four cores share, on a network whose paths are set up by a fixed time-division schedule. Each core posts one transmit request at a time, tagged with a destination node. Messages that arrived at this gateway only to change mesh dimension are held in an associative hop store. Every destination maps to a fixed slot of the repeating frame. When a slot boundary is signalled, the scheduler looks at all waiting requests whose slot equals the slot now starting. It grants one of them, steers the crossbar to the serializer for a fixed transmission window, and then frees the source.

Because a request waits only for its own slot, a core whose slot is far away never holds back a core whose slot comes sooner. Requests therefore complete out of order across sources. When several sources match the same slot, a rotating priority among the sources decides which one wins. The decision is taken at the slot boundary, so the crossbar select is stable for the whole window.

On the receive side, a two-entry buffer holds messages from the network that are bound for the gateway's cores. It feeds the delivery crossbar ahead of any core-to-core transfer inside the gateway.

Top module: `gw_tx_sched`

## Requirements
- R1: After reset, tx_active is 0, tx_grant is all zero, every core_req_ready is 1, hop_in_ready is 1, hop_pending is 0, rx_in_ready is 1, and dlv_valid is 0 while no input is valid.
- R2: A message to destination d belongs to slot (d + NODE_ID) mod NSLOT (defaults: NODE_ID 5, NSLOT 28). It is granted only on a slot_tick whose slot_idx equals that slot. Its window starts in the cycle after that tick, with tx_dest = d and tx_sel = source index (core c is c, the hop store is NCORE = 4).
- R3: A window keeps tx_active high for exactly TX_LEN (default 4) cycles. tx_sel and tx_dest stay constant during the window, and tx_grant equals the one-hot of tx_sel throughout.
- R4: A request waiting for a later slot does not block other sources. Grants follow slot order, not arrival order.
- R5: At most one source is granted per slot_tick, and tx_grant is never more than one-hot.
- R6: When several sources match the same slot, each grant goes to the first matching source at or after the one following the previous winner, in the cyclic order cores 0..3, then the hop store.
- R7: The hop store holds up to 2·(ROW−1) messages (14 by default). hop_in_ready is 0 when it is full, and a message offered while it is full is dropped. hop_pending is 1 while any message is held. Held messages go out in their own slots, whatever their insertion order.
- R8: A slot_tick that arrives while a window is in progress starts no grant.
- R9: The receive buffer holds 2 messages. rx_in_ready is 0 when it is full, and an offer made then is dropped. Messages leave in arrival order, one per cycle in which dlv_ready is 1, and the head stays put while dlv_ready is 0.
- R10: While the receive buffer holds any message, delivery comes from it (dlv_from_net = 1) and loc_ready is 0. A local transfer is delivered (dlv_from_net = 0, dlv_core = loc_core) only when the buffer is empty.
- R11: core_req_ready[c] is 0 from the cycle after a request is accepted until the cycle after its window ends, when it returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_tick | input | 1 | Pulse marking the start of a slot |
| slot_idx | input | 5 | Index of the slot that is starting |
| core_req_valid | input | 4 | Per-core transmit request valid |
| core_req_dest | input | 24 | Per-core destination node, 6 bits per core, core c at bits 6c+5:6c |
| core_req_ready | output | 4 | Per-core request accept |
| hop_in_valid | input | 1 | Dimension-change message offered to the hop store |
| hop_in_dest | input | 6 | Final destination of that message |
| hop_in_ready | output | 1 | Hop store has a free entry |
| hop_pending | output | 1 | Hop store holds at least one message |
| tx_active | output | 1 | Transmission window in progress |
| tx_grant | output | 5 | One-hot granted source (bit 4 = hop store) |
| tx_sel | output | 3 | Crossbar select toward the serializer |
| tx_dest | output | 6 | Destination of the granted message |
| rx_in_valid | input | 1 | Received message for a local core |
| rx_in_core | input | 2 | Target core of the received message |
| rx_in_ready | output | 1 | Receive buffer has room |
| loc_valid | input | 1 | Core-to-core transfer request |
| loc_core | input | 2 | Target core of the local transfer |
| loc_ready | output | 1 | Local transfer accepted this cycle |
| dlv_ready | input | 1 | Delivery crossbar can move a message this cycle |
| dlv_valid | output | 1 | A delivery is presented |
| dlv_core | output | 2 | Core receiving the delivery |
| dlv_from_net | output | 1 | 1 when the delivery comes from the receive buffer |

## Verification
The bench sweeps every destination for every core and for the hop store through a full frame of ticks. It checks that exactly one grant arrives in the computed slot, so a wrong slot mapping or an off-by-one on slot_idx shows up as a grant in the wrong slot or no grant at all. It posts requests whose slots run against their arrival order, which catches a queue that grants in arrival order. It loads all five sources onto one slot to check the rotation, which catches a fixed-priority arbiter. It ticks during a live window, which catches a design that overwrites the crossbar select mid-transmission. It fills the hop store in reverse slot order, offers one message too many, and then stalls the receive side with a local transfer waiting, which catches an overflowing store and a buffer that lets core-to-core traffic jump ahead of network deliveries.

// File: rtl/gw_sched_pkg.sv
package gw_sched_pkg;

    // Default geometry: an 8x8 mesh, four cores per gateway.
    localparam int DEF_ROW    = 8;
    localparam int DEF_NCORE  = 4;
    localparam int DEF_TX_LEN = 4;
    localparam int DEF_NODE   = 5;
    localparam int DEF_RX_BUF = 2;

    // Slots in a frame when two transfers share every row and column.
    function automatic int frame_slots(input int row);
        return (row - 1) * (row / 2);
    endfunction

    // Worst-case dimension-change backlog over one frame.
    function automatic int hop_capacity(input int row);
        return 2 * (row - 1);
    endfunction

    // Width helper that never returns zero.
    function automatic int width_of(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    typedef enum logic [0:0] {
        FROM_LOCAL = 1'b0,
        FROM_NET   = 1'b1
    } dlv_src_e;

endpackage

// File: rtl/gw_slot_lut.sv
module gw_slot_lut #(
    parameter int DEST_W  = 6,
    parameter int SLOT_W  = 5,
    parameter int NSLOT   = 28,
    parameter int NODE_ID = 5
) (
    input  logic [DEST_W-1:0] dest,
    output logic [SLOT_W-1:0] slot
);
    // Static schedule: this gateway talks to node d in slot (d + id) mod NSLOT.
    always_comb begin
        int s;
        s    = (int'(dest) + NODE_ID) % NSLOT;
        slot = SLOT_W'(s);
    end
endmodule

// File: rtl/gw_hop_store.sv
module gw_hop_store #(
    parameter int DEPTH  = 14,
    parameter int DEST_W = 6,
    parameter int IDX_W  = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    input  logic [DEST_W-1:0]            in_dest,
    output logic                         in_ready,
    input  logic                         clr_en,
    input  logic [IDX_W-1:0]             clr_idx,
    output logic [DEPTH-1:0]             ent_valid,
    output logic [DEPTH-1:0][DEST_W-1:0] ent_dest
);
    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!ent_valid[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    assign in_ready = any_free;

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_valid <= '0;
        end else begin
            if (clr_en) ent_valid[clr_idx] <= 1'b0;
            if (in_valid && any_free) ent_valid[free_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (in_valid && any_free) ent_dest[free_idx] <= in_dest;
    end

    // R7
    hop_full_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_ready && !clr_en) |=> !in_ready);

    // R7
    hop_clear_live_chk: assert property (@(posedge clk) disable iff (rst)
        clr_en |-> ent_valid[clr_idx]);
endmodule

// File: rtl/gw_tx_arb.sv
module gw_tx_arb #(
    parameter int NSRC   = 5,
    parameter int SEL_W  = 3,
    parameter int DEST_W = 6,
    parameter int AUX_W  = 4,
    parameter int TX_LEN = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        slot_tick,
    input  logic [NSRC-1:0]             match,
    input  logic [NSRC-1:0][DEST_W-1:0] src_dest,
    input  logic [NSRC-1:0][AUX_W-1:0]  src_aux,
    output logic                        tx_active,
    output logic [NSRC-1:0]             tx_grant,
    output logic [SEL_W-1:0]            tx_sel,
    output logic [DEST_W-1:0]           tx_dest,
    output logic [AUX_W-1:0]            tx_aux,
    output logic                        release_now
);
    localparam int CNT_W = gw_sched_pkg::width_of(TX_LEN);

    logic             busy;
    logic [CNT_W-1:0] cnt;
    logic [SEL_W-1:0] ptr;
    logic [SEL_W-1:0] win;
    logic             found;
    logic             start;

    // Rotating search starting at ptr.
    always_comb begin
        int idx;
        found = 1'b0;
        win   = '0;
        for (int k = 0; k < NSRC; k++) begin
            idx = (int'(ptr) + k) % NSRC;
            if (!found && match[idx]) begin
                found = 1'b1;
                win   = SEL_W'(idx);
            end
        end
    end

    assign start       = slot_tick && !busy && found;
    assign release_now = busy && (cnt == CNT_W'(TX_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            cnt     <= '0;
            ptr     <= '0;
            tx_sel  <= '0;
            tx_dest <= '0;
            tx_aux  <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            cnt     <= '0;
            tx_sel  <= win;
            tx_dest <= src_dest[win];
            tx_aux  <= src_aux[win];
            ptr     <= (int'(win) == NSRC - 1) ? '0 : win + SEL_W'(1);
        end else if (busy) begin
            if (release_now) busy <= 1'b0;
            else             cnt  <= cnt + CNT_W'(1);
        end
    end

    assign tx_active = busy;

    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            tx_grant[i] = busy && (tx_sel == SEL_W'(i));
        end
    end

    // R2
    grant_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(slot_tick));

    // R5
    grant_needs_match_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(match) != '0);

    // R3
    window_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$rose(busy)) |-> ($stable(tx_sel) && $stable(tx_dest)));

    // R8
    tick_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_tick && busy) |=> $stable(tx_sel));

    generate
        if (TX_LEN > 1) begin : g_multi
            // R3
            window_min_len_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(busy) |=> busy);
        end
    endgenerate
endmodule

// File: rtl/gw_rx_deliver.sv
module gw_rx_deliver #(
    parameter int DEPTH  = 2,
    parameter int CORE_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_in_valid,
    input  logic [CORE_W-1:0] rx_in_core,
    output logic              rx_in_ready,
    input  logic              loc_valid,
    input  logic [CORE_W-1:0] loc_core,
    output logic              loc_ready,
    input  logic              dlv_ready,
    output logic              dlv_valid,
    output logic [CORE_W-1:0] dlv_core,
    output gw_sched_pkg::dlv_src_e dlv_src
);
    import gw_sched_pkg::*;

    localparam int PTR_W = width_of(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DEPTH-1:0][CORE_W-1:0] mem;
    logic [PTR_W-1:0]             wp, rp;
    logic [CNT_W-1:0]             cnt;
    logic                         push, pop, held;

    assign held        = (cnt != '0);
    assign rx_in_ready = (cnt != CNT_W'(DEPTH));
    assign push        = rx_in_valid && rx_in_ready;
    assign pop         = held && dlv_ready;
    assign loc_ready   = !held && dlv_ready;

    assign dlv_valid = held || loc_valid;
    assign dlv_core  = held ? mem[rp] : loc_core;
    assign dlv_src   = held ? FROM_NET : FROM_LOCAL;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= (int'(wp) == DEPTH - 1) ? '0 : wp + PTR_W'(1);
            if (pop)  rp <= (int'(rp) == DEPTH - 1) ? '0 : rp + PTR_W'(1);
            if (push && !pop)      cnt <= cnt + CNT_W'(1);
            else if (pop && !push) cnt <= cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= rx_in_core;
    end

    // R9
    rx_head_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (held && !dlv_ready) |=> (dlv_src == FROM_NET && $stable(dlv_core)));

    // R9
    rx_full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (!rx_in_ready && !pop) |=> !rx_in_ready);

    // R10
    rx_before_local_chk: assert property (@(posedge clk) disable iff (rst)
        held |-> (!loc_ready && dlv_src == FROM_NET));
endmodule

// File: rtl/gw_tx_sched.sv
module gw_tx_sched
    import gw_sched_pkg::*;
#(
    parameter int NCORE    = DEF_NCORE,
    parameter int ROW      = DEF_ROW,
    parameter int NODE_ID  = DEF_NODE,
    parameter int TX_LEN   = DEF_TX_LEN,
    parameter int RX_DEPTH = DEF_RX_BUF,
    localparam int NNODE     = ROW * ROW,
    localparam int DEST_W    = width_of(NNODE),
    localparam int NSLOT     = frame_slots(ROW),
    localparam int SLOT_W    = width_of(NSLOT),
    localparam int HOP_DEPTH = hop_capacity(ROW),
    localparam int HOP_IW    = width_of(HOP_DEPTH),
    localparam int NSRC      = NCORE + 1,
    localparam int SEL_W     = width_of(NSRC),
    localparam int CORE_W    = width_of(NCORE)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     slot_tick,
    input  logic [SLOT_W-1:0]        slot_idx,
    input  logic [NCORE-1:0]         core_req_valid,
    input  logic [NCORE*DEST_W-1:0]  core_req_dest,
    output logic [NCORE-1:0]         core_req_ready,
    input  logic                     hop_in_valid,
    input  logic [DEST_W-1:0]        hop_in_dest,
    output logic                     hop_in_ready,
    output logic                     hop_pending,
    output logic                     tx_active,
    output logic [NSRC-1:0]          tx_grant,
    output logic [SEL_W-1:0]         tx_sel,
    output logic [DEST_W-1:0]        tx_dest,
    input  logic                     rx_in_valid,
    input  logic [CORE_W-1:0]        rx_in_core,
    output logic                     rx_in_ready,
    input  logic                     loc_valid,
    input  logic [CORE_W-1:0]        loc_core,
    output logic                     loc_ready,
    input  logic                     dlv_ready,
    output logic                     dlv_valid,
    output logic [CORE_W-1:0]        dlv_core,
    output logic                     dlv_from_net
);
    // Per-core single pending request.
    logic [NCORE-1:0]             pend;
    logic [NCORE-1:0][DEST_W-1:0] pend_dest;
    logic [NCORE-1:0][SLOT_W-1:0] core_slot;

    // Hop store view.
    logic [HOP_DEPTH-1:0]             hop_valid;
    logic [HOP_DEPTH-1:0][DEST_W-1:0] hop_dest;
    logic [HOP_DEPTH-1:0][SLOT_W-1:0] hop_slot;
    logic                             hop_hit;
    logic [HOP_IW-1:0]                hop_pick;

    // Arbiter view.
    logic [NSRC-1:0]             match;
    logic [NSRC-1:0][DEST_W-1:0] src_dest;
    logic [NSRC-1:0][HOP_IW-1:0] src_aux;
    logic [HOP_IW-1:0]           tx_aux;
    logic                        release_now;
    logic                        hop_clr;
    dlv_src_e                    dlv_src;

    generate
        for (genvar c = 0; c < NCORE; c++) begin : g_core
            gw_slot_lut #(
                .DEST_W (DEST_W),
                .SLOT_W (SLOT_W),
                .NSLOT  (NSLOT),
                .NODE_ID(NODE_ID)
            ) u_lut (
                .dest(pend_dest[c]),
                .slot(core_slot[c])
            );

            always_ff @(posedge clk) begin
                if (rst) begin
                    pend[c] <= 1'b0;
                end else if (core_req_valid[c] && !pend[c]) begin
                    pend[c] <= 1'b1;
                end else if (release_now && tx_sel == SEL_W'(c)) begin
                    pend[c] <= 1'b0;
                end
            end

            always_ff @(posedge clk) begin
                if (core_req_valid[c] && !pend[c])
                    pend_dest[c] <= core_req_dest[c*DEST_W +: DEST_W];
            end

            assign core_req_ready[c] = !pend[c];
            assign match[c]          = pend[c] && (core_slot[c] == slot_idx);
            assign src_dest[c]       = pend_dest[c];
            assign src_aux[c]        = '0;

            // R11
            core_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (pend[c] && !(release_now && tx_sel == SEL_W'(c))) |=> pend[c]);
        end

        for (genvar h = 0; h < HOP_DEPTH; h++) begin : g_hop
            gw_slot_lut #(
                .DEST_W (DEST_W),
                .SLOT_W (SLOT_W),
                .NSLOT  (NSLOT),
                .NODE_ID(NODE_ID)
            ) u_lut (
                .dest(hop_dest[h]),
                .slot(hop_slot[h])
            );
        end
    endgenerate

    // Lowest-numbered hop entry that fits the starting slot.
    always_comb begin
        hop_hit  = 1'b0;
        hop_pick = '0;
        for (int i = HOP_DEPTH - 1; i >= 0; i--) begin
            if (hop_valid[i] && hop_slot[i] == slot_idx) begin
                hop_hit  = 1'b1;
                hop_pick = HOP_IW'(i);
            end
        end
    end

    assign match[NCORE]    = hop_hit;
    assign src_dest[NCORE] = hop_dest[hop_pick];
    assign src_aux[NCORE]  = hop_pick;
    assign hop_clr         = release_now && (tx_sel == SEL_W'(NCORE));
    assign hop_pending     = |hop_valid;

    gw_hop_store #(
        .DEPTH (HOP_DEPTH),
        .DEST_W(DEST_W),
        .IDX_W (HOP_IW)
    ) u_hop (
        .clk      (clk),
        .rst      (rst),
        .in_valid (hop_in_valid),
        .in_dest  (hop_in_dest),
        .in_ready (hop_in_ready),
        .clr_en   (hop_clr),
        .clr_idx  (tx_aux),
        .ent_valid(hop_valid),
        .ent_dest (hop_dest)
    );

    gw_tx_arb #(
        .NSRC  (NSRC),
        .SEL_W (SEL_W),
        .DEST_W(DEST_W),
        .AUX_W (HOP_IW),
        .TX_LEN(TX_LEN)
    ) u_arb (
        .clk        (clk),
        .rst        (rst),
        .slot_tick  (slot_tick),
        .match      (match),
        .src_dest   (src_dest),
        .src_aux    (src_aux),
        .tx_active  (tx_active),
        .tx_grant   (tx_grant),
        .tx_sel     (tx_sel),
        .tx_dest    (tx_dest),
        .tx_aux     (tx_aux),
        .release_now(release_now)
    );

    gw_rx_deliver #(
        .DEPTH (RX_DEPTH),
        .CORE_W(CORE_W)
    ) u_rx (
        .clk        (clk),
        .rst        (rst),
        .rx_in_valid(rx_in_valid),
        .rx_in_core (rx_in_core),
        .rx_in_ready(rx_in_ready),
        .loc_valid  (loc_valid),
        .loc_core   (loc_core),
        .loc_ready  (loc_ready),
        .dlv_ready  (dlv_ready),
        .dlv_valid  (dlv_valid),
        .dlv_core   (dlv_core),
        .dlv_src    (dlv_src)
    );

    assign dlv_from_net = (dlv_src == FROM_NET);
endmodule

// File: tb/gw_tx_sched_bench.sv
module gw_tx_sched_bench;
    localparam int NCORE = 4, DW = 6, SW = 5, NSLOT = 28, NODE = 5, TXL = 4, HOPN = 14;
    localparam int SPACE = 7;

    logic clk = 1'b0, rst = 1'b1;
    logic slot_tick = 1'b0;
    logic [SW-1:0] slot_idx = '0;
    logic [NCORE-1:0] core_req_valid = '0;
    logic [NCORE*DW-1:0] core_req_dest = '0;
    logic [NCORE-1:0] core_req_ready;
    logic hop_in_valid = 1'b0;
    logic [DW-1:0] hop_in_dest = '0;
    logic hop_in_ready, hop_pending, tx_active;
    logic [NCORE:0] tx_grant;
    logic [2:0] tx_sel;
    logic [DW-1:0] tx_dest;
    logic rx_in_valid = 1'b0;
    logic [1:0] rx_in_core = '0;
    logic rx_in_ready;
    logic loc_valid = 1'b0;
    logic [1:0] loc_core = '0;
    logic loc_ready;
    logic dlv_ready = 1'b1;
    logic dlv_valid;
    logic [1:0] dlv_core;
    logic dlv_from_net;

    always #4 clk = ~clk;

    gw_tx_sched u_gw_tx_sched (
        .clk(clk), .rst(rst), .slot_tick(slot_tick), .slot_idx(slot_idx),
        .core_req_valid(core_req_valid), .core_req_dest(core_req_dest),
        .core_req_ready(core_req_ready), .hop_in_valid(hop_in_valid),
        .hop_in_dest(hop_in_dest), .hop_in_ready(hop_in_ready),
        .hop_pending(hop_pending), .tx_active(tx_active), .tx_grant(tx_grant),
        .tx_sel(tx_sel), .tx_dest(tx_dest), .rx_in_valid(rx_in_valid),
        .rx_in_core(rx_in_core), .rx_in_ready(rx_in_ready), .loc_valid(loc_valid),
        .loc_core(loc_core), .loc_ready(loc_ready), .dlv_ready(dlv_ready),
        .dlv_valid(dlv_valid), .dlv_core(dlv_core), .dlv_from_net(dlv_from_net)
    );

    int n_checks = 0, n_fail = 0;
    int drv_slot = -1;
    int ev_n = 0;
    int ev_src [64];
    int ev_slot[64];
    int ev_dest[64];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Window monitor: records grants and checks width and stability (R3, R5).
    bit prev_act = 1'b0;
    int run_len = 0;
    bit run_bad = 1'b0;
    logic [2:0] hold_sel;
    logic [DW-1:0] hold_dest;
    always @(negedge clk) begin
        if (rst) begin
            prev_act = 1'b0;
        end else begin
            if (tx_active && !prev_act) begin
                if (ev_n < 64) begin
                    ev_src[ev_n]  = int'(tx_sel);
                    ev_slot[ev_n] = drv_slot;
                    ev_dest[ev_n] = int'(tx_dest);
                end
                ev_n++;
                run_len = 1;
                run_bad = (tx_grant != (5'd1 << tx_sel));
                hold_sel = tx_sel;
                hold_dest = tx_dest;
                check(!run_bad, "R5 grant one-hot of select", int'(tx_grant), 1 << tx_sel);
            end else if (tx_active) begin
                run_len++;
                if (tx_sel != hold_sel || tx_dest != hold_dest
                    || tx_grant != (5'd1 << tx_sel)) run_bad = 1'b1;
            end else if (prev_act) begin
                check(run_len == TXL, "R3 window length", run_len, TXL);
                check(!run_bad, "R3 select and destination stable", int'(run_bad), 0);
            end
            prev_act = tx_active;
        end
    end

    function automatic int slot_of(input int d);
        return (d + NODE) % NSLOT;
    endfunction

    task automatic do_tick(input int s);
        @(posedge clk); #1;
        slot_tick = 1'b1; slot_idx = SW'(s); drv_slot = s;
        @(posedge clk); #1;
        slot_tick = 1'b0;
        repeat (SPACE - 1) @(posedge clk);
    endtask

    task automatic run_frame();
        for (int s = 0; s < NSLOT; s++) do_tick(s);
    endtask

    task automatic submit(input int c, input int d);
        @(posedge clk); #1;
        core_req_valid[c] = 1'b1;
        core_req_dest[c*DW +: DW] = DW'(d);
        @(posedge clk); #1;
        core_req_valid[c] = 1'b0;
    endtask

    task automatic push_hop(input int d);
        @(posedge clk); #1;
        hop_in_valid = 1'b1; hop_in_dest = DW'(d);
        @(posedge clk); #1;
        hop_in_valid = 1'b0;
    endtask

    task automatic push_rx(input int c);
        @(posedge clk); #1;
        rx_in_valid = 1'b1; rx_in_core = 2'(c);
        @(posedge clk); #1;
        rx_in_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(tx_active == 1'b0, "R1 tx_active", int'(tx_active), 0);
        check(tx_grant == '0, "R1 tx_grant", int'(tx_grant), 0);
        check(core_req_ready == 4'hF, "R1 core ready", int'(core_req_ready), 15);
        check(hop_in_ready == 1'b1, "R1 hop ready", int'(hop_in_ready), 1);
        check(hop_pending == 1'b0, "R1 hop pending", int'(hop_pending), 0);
        check(rx_in_ready == 1'b1, "R1 rx ready", int'(rx_in_ready), 1);
        check(dlv_valid == 1'b0, "R1 no delivery", int'(dlv_valid), 0);

        // R2 and R11: every core, every destination, one frame each.
        for (int c = 0; c < NCORE; c++) begin
            for (int d = 0; d < 64; d++) begin
                ev_n = 0;
                submit(c, d);
                check(core_req_ready[c] == 1'b0, "R11 ready low while held", int'(core_req_ready[c]), 0);
                run_frame();
                check(ev_n == 1, "R2 single grant per request", ev_n, 1);
                check(ev_src[0] == c && ev_slot[0] == slot_of(d) && ev_dest[0] == d,
                      "R2 grant slot", ev_slot[0], slot_of(d));
                check(core_req_ready[c] == 1'b1, "R11 ready back after window", int'(core_req_ready[c]), 1);
            end
        end

        // R2 for the hop store source.
        for (int d = 0; d < 64; d++) begin
            ev_n = 0;
            push_hop(d);
            check(hop_pending == 1'b1, "R7 pending after insert", int'(hop_pending), 1);
            run_frame();
            check(ev_n == 1 && ev_src[0] == NCORE && ev_slot[0] == slot_of(d) && ev_dest[0] == d,
                  "R2 hop grant slot", ev_slot[0], slot_of(d));
        end

        // R4: arrival order 0,1,2 but slots 20,3,10.
        ev_n = 0;
        submit(0, 15);
        submit(1, 26);
        submit(2, 5);
        run_frame();
        check(ev_n == 3, "R4 grant count", ev_n, 3);
        check(ev_src[0] == 1 && ev_slot[0] == 3, "R4 first grant core", ev_src[0], 1);
        check(ev_src[1] == 2 && ev_slot[1] == 10, "R4 second grant core", ev_src[1], 2);
        check(ev_src[2] == 0 && ev_slot[2] == 20, "R4 third grant core", ev_src[2], 0);

        // R6: all five sources in slot 12.
        ev_n = 0;
        for (int c = 0; c < NCORE; c++) submit(c, 7);
        push_hop(35);
        for (int k = 0; k < 5; k++) do_tick(12);
        check(ev_n == 5, "R6 grants for tied sources", ev_n, 5);
        check(ev_src[0] == 1, "R6 rotation after core 0 won last", ev_src[0], 1);
        for (int k = 1; k < 5; k++)
            check(ev_src[k] == (ev_src[0] + k) % 5 && ev_slot[k] == 12,
                  "R6 rotation order", ev_src[k], (ev_src[0] + k) % 5);

        // R8: tick for slot 6 lands inside the slot 5 window.
        ev_n = 0;
        submit(0, 0);
        submit(1, 1);
        @(posedge clk); #1;
        slot_tick = 1'b1; slot_idx = SW'(5); drv_slot = 5;
        @(posedge clk); #1;
        slot_tick = 1'b0;
        @(posedge clk); #1;
        slot_tick = 1'b1; slot_idx = SW'(6); drv_slot = 6;
        @(posedge clk); #1;
        slot_tick = 1'b0;
        repeat (8) @(posedge clk);
        check(ev_n == 1 && ev_src[0] == 0, "R8 tick in window ignored", ev_n, 1);
        check(core_req_ready[1] == 1'b0, "R8 core 1 still waiting", int'(core_req_ready[1]), 0);
        do_tick(6);
        check(ev_n == 2 && ev_src[1] == 1 && ev_slot[1] == 6, "R8 granted at next matching tick", ev_n, 2);

        // R7: fill the hop store in reverse slot order, then overfill.
        ev_n = 0;
        for (int d = HOPN - 1; d >= 0; d--) push_hop(d);
        #1;
        check(hop_in_ready == 1'b0, "R7 full store not ready", int'(hop_in_ready), 0);
        check(hop_pending == 1'b1, "R7 pending while full", int'(hop_pending), 1);
        push_hop(20);
        run_frame();
        check(ev_n == HOPN, "R7 all held sent, extra dropped", ev_n, HOPN);
        for (int k = 0; k < HOPN; k++)
            check(ev_src[k] == NCORE && ev_slot[k] == NODE + k && ev_dest[k] == k,
                  "R7 hop message in own slot", ev_slot[k], NODE + k);
        check(hop_pending == 1'b0, "R7 empty after frame", int'(hop_pending), 0);
        check(hop_in_ready == 1'b1, "R7 ready after drain", int'(hop_in_ready), 1);

        // R9 / R10: stalled delivery, two net messages, local waiting.
        dlv_ready = 1'b0;
        push_rx(1);
        push_rx(2);
        check(rx_in_ready == 1'b0, "R9 buffer full", int'(rx_in_ready), 0);
        push_rx(3);
        loc_valid = 1'b1; loc_core = 2'd0;
        @(negedge clk);
        check(dlv_valid && dlv_from_net && dlv_core == 2'd1, "R9 head held while stalled", int'(dlv_core), 1);
        check(loc_ready == 1'b0, "R10 local blocked by net", int'(loc_ready), 0);
        @(posedge clk); #1;
        dlv_ready = 1'b1;
        @(negedge clk);
        check(dlv_from_net && dlv_core == 2'd1, "R9 first net delivery", int'(dlv_core), 1);
        @(negedge clk);
        check(dlv_from_net && dlv_core == 2'd2, "R9 second net delivery", int'(dlv_core), 2);
        check(loc_ready == 1'b0, "R10 local still blocked", int'(loc_ready), 0);
        @(negedge clk);
        check(dlv_valid && !dlv_from_net && dlv_core == 2'd0, "R10 local after net drains",
              int'(dlv_from_net), 0);
        check(loc_ready == 1'b1, "R10 local accepted", int'(loc_ready), 1);
        @(posedge clk); #1;
        loc_valid = 1'b0;
        @(negedge clk);
        check(dlv_valid == 1'b0, "R9 overflow message dropped", int'(dlv_valid), 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule